// File: doc/BRIEF.md
# Scan Chain Test Controller

This block puts a small synchronous circuit whose state flops are all scan flops behind a controller that runs a complete scan test by itself. Each state flop has a two-way input select. With the shift control high, every flop takes its bit from the flop below it, so the whole state forms one serial shift register. With the shift control low, every flop takes its functional next state.

Software or a tester writes a test vector and its expected response into a one-entry holding buffer and then pulses start. The controller shifts the vector into the chain, drops the shift control for one capture clock, and then shifts the captured state out. While the response leaves the chain it checks each bit against the expected word. If another vector was written in the meantime, its bits enter the chain during that same unload. A sticky fail flag and a one-cycle done pulse report the outcome of the whole batch.

While no test is running, the circuit runs in functional mode from its primary inputs.

Top module: `scan_test_ctrl`

## Requirements
- R1: While `scan_en` is high, every clock moves chain bit i into bit i+1, `scan_in` enters bit 0, and `scan_out` always shows bit CHAIN_LEN-1.
- R2: While `scan_en` is low, the chain loads its functional next state. Each bit i takes bit (i-1) mod CHAIN_LEN; for i below PI_W, that value is XORed with primary input bit i. This is a rotate left by one with the primary inputs XORed into the low bits.
- R3: A test runs CHAIN_LEN shift cycles, then exactly one capture cycle with `scan_en` low, then CHAIN_LEN unload cycles. Vector bits enter most significant bit first, so after the load the chain equals the vector. Unloaded bits are compared most significant bit first against the expected word.
- R4: `fail` sets on the first unloaded bit that differs from the expected word. It stays set until the next accepted start clears it.
- R5: `done` is high for exactly one cycle. With a single vector, it rises on the 2*CHAIN_LEN+1-th rising edge after the edge that accepts start. The last comparison updates `fail` on that same edge.
- R6: A vector written while a test runs, and pending at a capture cycle, is shifted in during that unload and gets its own capture and unload. Each extra vector adds CHAIN_LEN+1 cycles before `done`, and `done` comes only after the last one.
- R7: `start` is accepted only when the controller is idle and a vector is pending. Otherwise it has no effect: `scan_en` stays low and no `done` follows.
- R8: Every capture in a run uses the primary input value sampled at the accepted start, even if `func_in` changes later.
- R9: `func_out` holds its value on every clock where `scan_en` is high. On other clocks it loads the low PO_W bits of the chain.
- R10: A vector load writes a one-entry buffer. A second load before the buffer is consumed replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run |
| vec_load | input | 1 | Write vector and expected word into the buffer |
| vec_data | input | CHAIN_LEN | Test vector |
| exp_data | input | CHAIN_LEN | Expected captured response |
| func_in | input | PI_W | Primary inputs |
| func_out | output | PO_W | Registered primary outputs |
| scan_en | output | 1 | Shift control of the chain |
| scan_in | output | 1 | Serial bit entering the chain |
| scan_out | output | 1 | Serial bit leaving the chain |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The assertions check the following on every cycle:
- the shift behaviour of the chain;
- that a low `scan_en` inside a run lasts exactly one cycle;
- the single-cycle `done` pulse, the stickiness and clearing of `fail`, and the range of the bit counter;
- that an unaccepted start leaves the controller idle;
- that `func_out` holds during shifting.

The capture function, the bit order of load and unload, the held primary inputs, buffer overwrite, and the end-to-end latency of single and overlapped batches are shown only by the bench scenarios. These scenarios compare the outcome and timing of each batch against a response model of their own.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_CAPT = 2'd2,
    ST_UNLD = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_cut.sv
// Circuit under test: one scan flop per state bit, each with a shift/functional select.
module scan_cut #(
  parameter int N  = 16,
  parameter int PI = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan_en,
  input  logic          scan_in,
  input  logic [PI-1:0] pi,
  output logic [N-1:0]  chain,
  output logic          scan_out
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int PREV = (i + N - 1) % N;
    logic sh_src, fn_src, q;
    if (i == 0) begin : g_head
      assign sh_src = scan_in;
    end else begin : g_link
      assign sh_src = chain[i-1];
    end
    if (i < PI) begin : g_mix
      assign fn_src = chain[PREV] ^ pi[i];
    end else begin : g_rot
      assign fn_src = chain[PREV];
    end
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= scan_en ? sh_src : fn_src;
    end
    assign chain[i] = q;
  end

  assign scan_out = chain[N-1];

  // R1: shift moves every bit up by one and takes scan_in at the bottom
  a_r1_shift: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (chain[N-1:1] == $past(chain[N-2:0])) && (chain[0] == $past(scan_in)));
endmodule

// File: rtl/scan_vbuf.sv
// One-entry holding buffer for the next vector and its expected response.
module scan_vbuf #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [N-1:0] wr_vec,
  input  logic [N-1:0] wr_exp,
  input  logic         take,
  output logic         valid,
  output logic [N-1:0] vec,
  output logic [N-1:0] exp_w
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      vec   <= '0;
      exp_w <= '0;
    end else begin
      if (wr) begin
        valid <= 1'b1;
        vec   <= wr_vec;
        exp_w <= wr_exp;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end

  // R10: a write always leaves an entry pending
  a_r10_write_pending: assert property (@(posedge clk) disable iff (rst)
    wr |=> valid);
endmodule

// File: rtl/scan_seq.sv
// Sequencer: load, single capture, unload with overlapped next load, on-the-fly compare.
module scan_seq
  import scan_pkg::*;
#(
  parameter int N  = 16,
  parameter int PI = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pend_valid,
  input  logic [N-1:0]  pend_vec,
  input  logic [N-1:0]  pend_exp,
  output logic          pend_take,
  input  logic [PI-1:0] func_in,
  output logic [PI-1:0] pi_used,
  input  logic          chain_out,
  output logic          scan_en,
  output logic          scan_in,
  output logic          done,
  output logic          fail
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  scan_state_e   st;
  logic [CW-1:0] cnt;
  logic [N-1:0]  ld_sh, cur_exp, chk_sh;
  logic          more;
  logic [PI-1:0] pi_hold;
  logic          go;

  assign go        = (st == ST_IDLE) && start && pend_valid;
  assign pend_take = go || ((st == ST_CAPT) && pend_valid);
  assign scan_en   = (st == ST_LOAD) || (st == ST_UNLD);
  assign scan_in   = ld_sh[N-1];
  assign pi_used   = (st == ST_IDLE) ? func_in : pi_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      ld_sh   <= '0;
      cur_exp <= '0;
      chk_sh  <= '0;
      more    <= 1'b0;
      pi_hold <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st      <= ST_LOAD;
            cnt     <= '0;
            ld_sh   <= pend_vec;
            cur_exp <= pend_exp;
            pi_hold <= func_in;
            fail    <= 1'b0;
          end
        end
        ST_LOAD: begin
          ld_sh <= ld_sh << 1;
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= ST_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAPT: begin
          st     <= ST_UNLD;
          cnt    <= '0;
          chk_sh <= cur_exp;
          if (pend_valid) begin
            ld_sh   <= pend_vec;
            cur_exp <= pend_exp;
            more    <= 1'b1;
          end else begin
            ld_sh <= '0;
            more  <= 1'b0;
          end
        end
        default: begin
          ld_sh  <= ld_sh << 1;
          chk_sh <= chk_sh << 1;
          if (chain_out != chk_sh[N-1]) fail <= 1'b1;
          if (cnt == LAST) begin
            cnt <= '0;
            if (more) begin
              st <= ST_CAPT;
            end else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3: counter never leaves 0..N-1
  always_comb begin
    if (!rst) a_r3_cnt_range: assert (cnt <= LAST);
  end
  // R3: a low scan_en inside a run lasts one clock only
  a_r3_one_capture: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && st != ST_IDLE) |=> scan_en);
  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: fail stays set until an accepted start
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail && !go) |=> fail);
  // R4: accepted start clears fail
  a_r4_fail_clear: assert property (@(posedge clk) disable iff (rst)
    go |=> !fail);
  // R7: start without a pending vector leaves the controller idle
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !pend_valid) |=> (st == ST_IDLE));
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl #(
  parameter int CHAIN_LEN = 16,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 vec_load,
  input  logic [CHAIN_LEN-1:0] vec_data,
  input  logic [CHAIN_LEN-1:0] exp_data,
  input  logic [PI_W-1:0]      func_in,
  output logic [PO_W-1:0]      func_out,
  output logic                 scan_en,
  output logic                 scan_in,
  output logic                 scan_out,
  output logic                 done,
  output logic                 fail
);
  logic                 pend_valid, pend_take;
  logic [CHAIN_LEN-1:0] pend_vec, pend_exp, chain;
  logic [PI_W-1:0]      pi_used;

  scan_vbuf #(.N(CHAIN_LEN)) u_vbuf (
    .clk(clk), .rst(rst), .wr(vec_load), .wr_vec(vec_data), .wr_exp(exp_data),
    .take(pend_take), .valid(pend_valid), .vec(pend_vec), .exp_w(pend_exp)
  );

  scan_seq #(.N(CHAIN_LEN), .PI(PI_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .pend_valid(pend_valid),
    .pend_vec(pend_vec), .pend_exp(pend_exp), .pend_take(pend_take),
    .func_in(func_in), .pi_used(pi_used), .chain_out(scan_out),
    .scan_en(scan_en), .scan_in(scan_in), .done(done), .fail(fail)
  );

  scan_cut #(.N(CHAIN_LEN), .PI(PI_W)) u_cut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in), .pi(pi_used),
    .chain(chain), .scan_out(scan_out)
  );

  always_ff @(posedge clk) begin
    if (rst)           func_out <= '0;
    else if (!scan_en) func_out <= chain[PO_W-1:0];
  end

  // R9: primary outputs frozen while shifting
  a_r9_po_hold: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> $stable(func_out));
endmodule

// File: tb/scan_test_ctrl_bench.sv
`timescale 1ns/1ps
module scan_test_ctrl_bench;
  localparam int N  = 16;
  localparam int PI = 4;
  localparam int PO = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, vec_load = 1'b0;
  logic [N-1:0]  vec_data = '0, exp_data = '0;
  logic [PI-1:0] func_in = '0;
  logic [PO-1:0] func_out;
  logic          scan_en, scan_in, scan_out, done, fail;

  always #2.5 clk = ~clk;

  scan_test_ctrl #(.CHAIN_LEN(N), .PI_W(PI), .PO_W(PO)) u_scan_test_ctrl (
    .clk(clk), .rst(rst), .start(start), .vec_load(vec_load), .vec_data(vec_data),
    .exp_data(exp_data), .func_in(func_in), .func_out(func_out), .scan_en(scan_en),
    .scan_in(scan_in), .scan_out(scan_out), .done(done), .fail(fail)
  );

  int total = 0, bad = 0;
  typedef struct { bit f; int e; } exp_t;
  exp_t sbq[$];
  logic arm = 1'b0;
  int   edges = 0;
  logic done_d = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [N-1:0] cap(logic [N-1:0] v, logic [PI-1:0] p);
    return {v[N-2:0], v[N-1]} ^ {{(N-PI){1'b0}}, p};
  endfunction

  always @(posedge clk) begin
    if (arm) edges <= 0;
    else     edges <= edges + 1;
  end

  // Monitor: pop an expected outcome on each done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (done && done_d) chk("R5 done width", 32'd2, 32'd1);
      if (done) begin
        if (sbq.size() == 0) begin
          chk("R7 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t x;
          x = sbq.pop_front();
          chk("R4 fail outcome", 32'(fail), 32'(x.f));
          chk("R5/R6 done latency", 32'(edges), 32'(x.e));
        end
      end
      done_d <= done;
    end
  end

  task automatic load_vec(logic [N-1:0] v, logic [N-1:0] e);
    @(negedge clk);
    vec_load = 1'b1; vec_data = v; exp_data = e;
    @(negedge clk);
    vec_load = 1'b0;
  endtask

  task automatic go(logic [PI-1:0] p);
    @(negedge clk);
    func_in = p; start = 1'b1; arm = 1'b1;
    @(negedge clk);
    start = 1'b0; arm = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_single(logic [N-1:0] v, logic [N-1:0] e, logic [PI-1:0] p, bit ef);
    logic [PO-1:0] fo1;
    logic [N-1:0]  c;
    c = cap(v, p);
    load_vec(v, e);
    sbq.push_back('{ef, 2*N+1});
    go(p);
    @(negedge clk);
    fo1 = func_out;
    repeat (N-1) @(negedge clk);
    chk("R9 func_out held in load", 32'(func_out), 32'(fo1));
    @(negedge clk);
    chk("R3 chain equals vector (func_out)", 32'(func_out), 32'(v[PO-1:0]));
    chk("R2 first unload bit", 32'(scan_out), 32'(c[N-1]));
    @(negedge clk);
    chk("R1 second unload bit", 32'(scan_out), 32'(c[N-2]));
    drain();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset scan_en", 32'(scan_en), 32'd0);
    chk("R4 reset fail", 32'(fail), 32'd0);
    chk("R5 reset done", 32'(done), 32'd0);
    chk("R9 reset func_out", 32'(func_out), 32'd0);

    // R7: start with nothing pending is ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k == 9) chk("R7 scan_en stays low", 32'(scan_en), 32'd0);
    end

    // single vector, correct response
    run_single(16'hA5C3, cap(16'hA5C3, 4'h5), 4'h5, 1'b0);
    // single vector, last compared bit wrong
    run_single(16'h1234, cap(16'h1234, 4'h9) ^ 16'h0001, 4'h9, 1'b1);
    chk("R4 fail stays after run", 32'(fail), 32'd1);
    // R4: new start clears fail
    run_single(16'hFFFF, cap(16'hFFFF, 4'h0), 4'h0, 1'b0);

    // R10: second load overwrites the pending one
    load_vec(16'h0F0F, 16'h0000);
    run_single(16'h8001, cap(16'h8001, 4'h3), 4'h3, 1'b0);

    // R6 + R8: overlapped second vector, func_in changed mid-run, second wrong
    load_vec(16'h5555, cap(16'h5555, 4'h6));
    sbq.push_back('{1'b1, 3*N+2});
    go(4'h6);
    repeat (3) @(negedge clk);
    func_in = 4'h9;
    load_vec(16'h00F0, cap(16'h00F0, 4'h6) ^ 16'h0100);
    drain();

    // R6: first wrong, second right -> still fail
    load_vec(16'hC001, cap(16'hC001, 4'h2) ^ 16'h8000);
    sbq.push_back('{1'b1, 3*N+2});
    go(4'h2);
    repeat (3) @(negedge clk);
    load_vec(16'h7E7E, cap(16'h7E7E, 4'h2));
    drain();

    // R6 + R8: three vectors all right, func_in changes
    load_vec(16'h1357, cap(16'h1357, 4'hB));
    sbq.push_back('{1'b0, 4*N+3});
    go(4'hB);
    repeat (3) @(negedge clk);
    load_vec(16'h2468, cap(16'h2468, 4'hB));
    func_in = 4'h0;
    repeat (16) @(negedge clk);
    load_vec(16'hBEEF, cap(16'hBEEF, 4'hB));
    drain();
    chk("R6 pass after batch", 32'(fail), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule